// File: doc/BRIEF.md
# Serial NOR Flash Burst Mover

This block moves a single burst of bytes between a serial NOR flash device and system memory with no processor help once the burst has begun. Before the burst, software sets up a flash start address, a memory start address, a byte count, an address width of three or four bytes, a lane mode and a dummy byte count for reads. A write of a control word carrying the start bit then launches the burst. That word also holds the read opcode, the write opcode and a direction bit.

The engine holds chip select low for the whole burst. It shifts out the opcode, then the address bytes, then any dummy bytes, and then moves the data on one, two or four lanes. Each flash byte goes through a byte-wide request/acknowledge memory port. A slow memory stretches the serial clock and never loses a byte. At the end the engine raises chip select and sets a sticky completion flag, which a clear pulse resets.

Top module: `fdma_top`

## Requirements
- R1: A burst starts only when `ctrl_we` is high, `ctrl_word[0]` is 1, `mode_reg[0]` is 1 and the engine is idle. With `mode_reg[0]`=0 the write has no effect: chip select stays high and `done` stays 0.
- R2: The opcode is the first byte out on `spi_io_out[0]` alone, MSB first. It is `ctrl_word[23:16]` when `ctrl_word[1]`=0 (flash to memory) and `ctrl_word[15:8]` when `ctrl_word[1]`=1 (memory to flash).
- R3: The address bytes follow the opcode, most significant byte first. There are three (`flash_addr[23:0]`) when `mode_reg[10]`=0 and four when `mode_reg[10]`=1.
- R4: For reads, `op_cfg[3:0]` dummy bytes follow the address with all outputs undriven. Writes send no dummy bytes whatever that field holds.
- R5: `op_cfg[9:7]` sets the lanes. Code 0 is single lane for every phase. Codes 1 and 3 put only the data on 2 or 4 lanes. Codes 2 and 4 put address, dummy and data on 2 or 4 lanes. Codes 5 to 7 act as 0. Wide lanes carry the higher bits first on the higher-numbered line. Single-lane input is taken from `spi_io_in[1]`.
- R6: In a read, each flash byte is written to memory (`mem_we`=1) at consecutive addresses starting at `mem_base`.
- R7: In a write, each byte is fetched from memory (`mem_we`=0) at consecutive addresses starting at `mem_base`, and then shifted out to the flash.
- R8: The data byte count is `xfer_len` limited to 4096. A count of 0 ends the burst right after the address or dummy phase.
- R9: A memory request holds its address, direction and data until `mem_ack`. While it waits, `spi_sck` stays low.
- R10: `spi_cs_n` stays low from the start to the last data bit and rises once per burst. `spi_sck` runs at half the clock rate and only while chip select is low. No lane is driven while chip select is high.
- R11: `done` rises together with chip select at the end of a burst and then holds. A `done_clr` pulse clears it. A start request during a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_reg | input | 11 | Bit 0 normal mode, bit 10 four-byte address |
| op_cfg | input | 10 | [9:7] lane mode, [3:0] dummy bytes |
| flash_addr | input | 32 | Flash start address |
| mem_base | input | ADDR_W | Memory start address |
| xfer_len | input | LEN_W | Byte count |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_word | input | 24 | Opcodes, direction, start |
| done_clr | input | 1 | Clears `done` |
| done | output | 1 | Sticky completion flag |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Byte to memory |
| mem_rdata | input | 8 | Byte from memory |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A wrong phase counter or lane decode shows up on the serial lines in the same beat: the bit pattern or the output enable mask no longer matches the expected opcode, address or data. A wrong byte counter shows up only at the end of the burst, as a wrong total of serial clock rises or memory accesses. A wrong memory address pointer shows up on the next access. A broken handshake shows up as a clock pulse during a pending request or as a request that changes before its acknowledge.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  typedef enum logic [1:0] {
    LW1 = 2'd0,
    LW2 = 2'd1,
    LW4 = 2'd2
  } lane_w_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_RSHIFT,
    ST_RSTORE, ST_WFETCH, ST_WSHIFT, ST_END
  } st_e;

  localparam int MODE_NORMAL_BIT = 0;
  localparam int MODE_ADDR4_BIT  = 10;
  localparam int CTRL_START_BIT  = 0;
  localparam int CTRL_DIR_BIT    = 1;

  function automatic logic [3:0] lane_mask(lane_w_e w);
    case (w)
      LW2:     lane_mask = 4'b0011;
      LW4:     lane_mask = 4'b1111;
      default: lane_mask = 4'b0001;
    endcase
  endfunction

  function automatic logic [2:0] beats_less_one(lane_w_e w);
    case (w)
      LW2:     beats_less_one = 3'd3;
      LW4:     beats_less_one = 3'd1;
      default: beats_less_one = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/fdma_lane_dec.sv
module fdma_lane_dec
  import fdma_pkg::*;
(
  input  logic [2:0] if_type,
  output lane_w_e    addr_w,
  output lane_w_e    data_w
);
  always_comb begin
    addr_w = LW1;
    data_w = LW1;
    case (if_type)
      3'd1: data_w = LW2;
      3'd2: begin addr_w = LW2; data_w = LW2; end
      3'd3: data_w = LW4;
      3'd4: begin addr_w = LW4; data_w = LW4; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fdma_shifter.sv
module fdma_shifter
  import fdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] tx_byte,
  input  lane_w_e    width,
  input  logic       drive,
  input  logic [3:0] io_in,
  output logic       sck,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic       idle,
  output logic [7:0] rx_byte
);
  logic       active_q, phase_q, drv_q;
  logic [7:0] sh_q, rx_q;
  logic [2:0] beats_q;
  lane_w_e    wid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      drv_q    <= 1'b0;
      sh_q     <= '0;
      rx_q     <= '0;
      beats_q  <= '0;
      wid_q    <= LW1;
    end else if (load && !active_q) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      sh_q     <= tx_byte;
      wid_q    <= width;
      drv_q    <= drive;
      beats_q  <= beats_less_one(width);
    end else if (active_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        case (wid_q)
          LW2: begin
            sh_q <= {sh_q[5:0], 2'b00};
            rx_q <= {rx_q[5:0], io_in[1:0]};
          end
          LW4: begin
            sh_q <= {sh_q[3:0], 4'b0000};
            rx_q <= {rx_q[3:0], io_in};
          end
          default: begin
            sh_q <= {sh_q[6:0], 1'b0};
            rx_q <= {rx_q[6:0], io_in[1]};
          end
        endcase
        if (beats_q == 3'd0) active_q <= 1'b0;
        else                 beats_q  <= beats_q - 3'd1;
      end
    end
  end

  always_comb begin
    io_out = 4'b0000;
    if (active_q) begin
      case (wid_q)
        LW2:     io_out = {2'b00, sh_q[7:6]};
        LW4:     io_out = sh_q[7:4];
        default: io_out = {3'b000, sh_q[7]};
      endcase
    end
  end

  assign io_oe   = (active_q && drv_q) ? lane_mask(wid_q) : 4'b0000;
  assign sck     = active_q & phase_q;
  assign idle    = ~active_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/fdma_top.sv
module fdma_top
  import fdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 28,
  parameter int MAX_BURST = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [10:0]       mode_reg,
  input  logic [9:0]        op_cfg,
  input  logic [31:0]       flash_addr,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              ctrl_we,
  input  logic [23:0]       ctrl_word,
  input  logic              done_clr,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  st_e               state_q;
  logic              dir_wr_q, addr4_q, pend_q, cs_n_q, done_q;
  logic              req_q, we_q;
  logic [7:0]        opcode_q, byte_buf_q, wdata_q;
  logic [3:0]        dummy_q;
  logic [31:0]       fa_sh_q;
  logic [CNT_W-1:0]  cnt_q, len_q;
  logic [ADDR_W-1:0] maddr_q;
  lane_w_e           aw_q, dw_q, dec_aw, dec_dw;

  logic              sh_load, sh_drive, sh_idle;
  logic [7:0]        sh_byte, sh_rx;
  lane_w_e           sh_w;
  logic              ready, fin, start_ok;
  logic [CNT_W-1:0]  len_clamped;
  st_e               data_st;

  logic unused_bits;
  assign unused_bits = ^{mode_reg[9:1], op_cfg[6:4], ctrl_word[7:2]};

  fdma_lane_dec u_dec (
    .if_type (op_cfg[9:7]),
    .addr_w  (dec_aw),
    .data_w  (dec_dw)
  );

  fdma_shifter u_sh (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .tx_byte (sh_byte),
    .width   (sh_w),
    .drive   (sh_drive),
    .io_in   (spi_io_in),
    .sck     (spi_sck),
    .io_out  (spi_io_out),
    .io_oe   (spi_io_oe),
    .idle    (sh_idle),
    .rx_byte (sh_rx)
  );

  assign ready    = sh_idle && !pend_q;
  assign fin      = sh_idle && pend_q;
  assign start_ok = ctrl_we && ctrl_word[CTRL_START_BIT] &&
                    mode_reg[MODE_NORMAL_BIT] && (state_q == ST_IDLE);
  assign len_clamped = (xfer_len > LEN_W'(MAX_BURST)) ? CNT_W'(MAX_BURST)
                                                      : xfer_len[CNT_W-1:0];

  always_comb begin
    if (len_q == '0)  data_st = ST_END;
    else if (dir_wr_q) data_st = ST_WFETCH;
    else               data_st = ST_RSHIFT;
  end

  always_comb begin
    sh_byte  = 8'h00;
    sh_w     = LW1;
    sh_drive = 1'b0;
    sh_load  = 1'b0;
    case (state_q)
      ST_CMD:    begin sh_byte = opcode_q;        sh_drive = 1'b1; sh_load = ready; end
      ST_ADDR:   begin sh_byte = fa_sh_q[31:24];  sh_w = aw_q; sh_drive = 1'b1; sh_load = ready; end
      ST_DUMMY:  begin sh_w = aw_q; sh_load = ready; end
      ST_RSHIFT: begin sh_byte = 8'hFF; sh_w = dw_q; sh_load = ready; end
      ST_WSHIFT: begin sh_byte = byte_buf_q; sh_w = dw_q; sh_drive = 1'b1; sh_load = ready; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      dir_wr_q   <= 1'b0;
      addr4_q    <= 1'b0;
      pend_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      req_q      <= 1'b0;
      we_q       <= 1'b0;
      opcode_q   <= '0;
      byte_buf_q <= '0;
      wdata_q    <= '0;
      dummy_q    <= '0;
      fa_sh_q    <= '0;
      cnt_q      <= '0;
      len_q      <= '0;
      maddr_q    <= '0;
      aw_q       <= LW1;
      dw_q       <= LW1;
    end else begin
      if (done_clr) done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q  <= ST_CMD;
          cs_n_q   <= 1'b0;
          dir_wr_q <= ctrl_word[CTRL_DIR_BIT];
          opcode_q <= ctrl_word[CTRL_DIR_BIT] ? ctrl_word[15:8] : ctrl_word[23:16];
          dummy_q  <= ctrl_word[CTRL_DIR_BIT] ? 4'd0 : op_cfg[3:0];
          addr4_q  <= mode_reg[MODE_ADDR4_BIT];
          fa_sh_q  <= mode_reg[MODE_ADDR4_BIT] ? flash_addr : {flash_addr[23:0], 8'h00};
          aw_q     <= dec_aw;
          dw_q     <= dec_dw;
          len_q    <= len_clamped;
          maddr_q  <= mem_base;
        end
        ST_CMD: begin
          if (ready) pend_q <= 1'b1;
          if (fin) begin
            pend_q  <= 1'b0;
            state_q <= ST_ADDR;
            cnt_q   <= addr4_q ? CNT_W'(4) : CNT_W'(3);
          end
        end
        ST_ADDR: begin
          if (ready) begin
            pend_q  <= 1'b1;
            fa_sh_q <= {fa_sh_q[23:0], 8'h00};
          end
          if (fin) begin
            pend_q <= 1'b0;
            if (cnt_q == CNT_W'(1)) begin
              if (dummy_q != 4'd0) begin
                state_q <= ST_DUMMY;
                cnt_q   <= CNT_W'(dummy_q);
              end else begin
                state_q <= data_st;
                cnt_q   <= len_q;
                req_q   <= (data_st == ST_WFETCH);
                we_q    <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_DUMMY: begin
          if (ready) pend_q <= 1'b1;
          if (fin) begin
            pend_q <= 1'b0;
            if (cnt_q == CNT_W'(1)) begin
              state_q <= data_st;
              cnt_q   <= len_q;
              req_q   <= (data_st == ST_WFETCH);
              we_q    <= 1'b0;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_RSHIFT: begin
          if (ready) pend_q <= 1'b1;
          if (fin) begin
            pend_q  <= 1'b0;
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            wdata_q <= sh_rx;
            state_q <= ST_RSTORE;
          end
        end
        ST_RSTORE: if (mem_ack) begin
          req_q   <= 1'b0;
          maddr_q <= maddr_q + ADDR_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= ST_END;
          else begin
            cnt_q   <= cnt_q - CNT_W'(1);
            state_q <= ST_RSHIFT;
          end
        end
        ST_WFETCH: if (mem_ack) begin
          req_q      <= 1'b0;
          byte_buf_q <= mem_rdata;
          maddr_q    <= maddr_q + ADDR_W'(1);
          state_q    <= ST_WSHIFT;
        end
        ST_WSHIFT: begin
          if (ready) pend_q <= 1'b1;
          if (fin) begin
            pend_q <= 1'b0;
            if (cnt_q == CNT_W'(1)) state_q <= ST_END;
            else begin
              cnt_q   <= cnt_q - CNT_W'(1);
              req_q   <= 1'b1;
              we_q    <= 1'b0;
              state_q <= ST_WFETCH;
            end
          end
        end
        ST_END: begin
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign spi_cs_n  = cs_n_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/fdma_chk.sv
module fdma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [10:0]       mode_reg,
  input logic              ctrl_we,
  input logic [23:0]       ctrl_word,
  input logic              done,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic [3:0]        spi_io_oe,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack
);
  // R10
  sck_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n);

  // R10
  sck_half_rate_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sck |=> !spi_sck);

  // R10
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (spi_io_oe == 4'b0000));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R9
  stall_no_clock_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !spi_sck);

  // R11
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $rose(spi_cs_n));

  // R1
  boot_mode_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_word[0] && !mode_reg[0] && spi_cs_n) |=> spi_cs_n);
endmodule

bind fdma_top fdma_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_fdma_top.sv
module tb_fdma_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mode_reg = '0;
  logic [9:0]  op_cfg = '0;
  logic [31:0] flash_addr = '0, mem_base = '0;
  logic [27:0] xfer_len = '0;
  logic        ctrl_we = 1'b0, done_clr = 1'b0;
  logic [23:0] ctrl_word = '0;
  logic        done, spi_sck, spi_cs_n, mem_req, mem_we;
  logic [3:0]  spi_io_out, spi_io_oe;
  logic [3:0]  spi_io_in = '0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdma_top dut (
    .clk(clk), .rst(rst), .mode_reg(mode_reg), .op_cfg(op_cfg),
    .flash_addr(flash_addr), .mem_base(mem_base), .xfer_len(xfer_len),
    .ctrl_we(ctrl_we), .ctrl_word(ctrl_word), .done_clr(done_clr),
    .done(done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, fails = 0, cyc = 0;
  int t_dir, t_nab, t_nd, t_n, t_aw, t_dw;
  logic [31:0] t_fa, t_mb;
  logic [7:0]  t_opc;
  int beat_k, beat_err, mem_k, mem_err, stall_err, cs_rises, cs_low;
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_wait = 1'b0;
  logic [31:0] prev_maddr = '0;

  function automatic logic [7:0] fdata(logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] mdata(logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h3C;
  endfunction

  function automatic int lanes(int code, bit data);
    if (data) return (code == 1 || code == 2) ? 2 : (code == 3 || code == 4) ? 4 : 1;
    return (code == 2) ? 2 : (code == 4) ? 4 : 1;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic beat_info(input int k, output int kind, output int w,
                           output logic [7:0] byt, output int pos);
    int kk, bpa, bpd, idx;
    kk = k; kind = 0; w = 1; byt = '0; pos = 0;
    bpa = 8 / t_aw; bpd = 8 / t_dw;
    if (kk < 8) begin kind = 1; byt = t_opc; pos = kk; return; end
    kk -= 8;
    if (kk < t_nab * bpa) begin
      kind = 1; w = t_aw; idx = kk / bpa; pos = kk % bpa;
      byt = 8'(t_fa >> (8 * (t_nab - 1 - idx)));
      return;
    end
    kk -= t_nab * bpa;
    if (kk < t_nd * bpa) begin kind = 2; return; end
    kk -= t_nd * bpa;
    if (kk < t_n * bpd) begin
      idx = kk / bpd; pos = kk % bpd; w = t_dw;
      if (t_dir != 0) begin kind = 1; byt = mdata(t_mb + 32'(idx)); end
      else            begin kind = 3; byt = fdata(t_fa + 32'(idx)); end
    end
  endtask

  // Flash and memory models, sampled away from the active edge
  always @(negedge clk) begin
    int kind, w, pos;
    logic [7:0] byt;
    logic [3:0] mask, bits;
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual %0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (!spi_cs_n) cs_low++;
    if (spi_cs_n && !prev_cs) cs_rises++;
    prev_cs = spi_cs_n;
    spi_io_in <= 4'b0000;
    if (spi_sck && !prev_sck) begin
      beat_info(beat_k, kind, w, byt, pos);
      mask = (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0001;
      bits = 4'((byt >> (8 - w * (pos + 1))) & ((1 << w) - 1));
      if (kind == 1) begin
        if (spi_io_oe !== mask || (spi_io_out & mask) !== bits) beat_err++;
      end else if (kind == 0) begin
        beat_err++;
      end else begin
        if (spi_io_oe !== 4'b0000) beat_err++;
        if (kind == 3) spi_io_in <= (w == 1) ? {2'b00, bits[0], 1'b0} : bits;
      end
      beat_k++;
    end
    prev_sck = spi_sck;
    mem_ack <= 1'b0;
    if (mem_req) begin
      if (spi_sck) stall_err++;
      if (prev_wait && mem_addr !== prev_maddr) stall_err++;
      prev_maddr = mem_addr;
      if ($urandom_range(0, 3) != 0) begin
        mem_ack <= 1'b1;
        prev_wait = 1'b0;
        if (mem_addr !== t_mb + 32'(mem_k)) mem_err++;
        if (mem_we) begin
          if (t_dir != 0 || mem_wdata !== fdata(t_fa + 32'(mem_k))) mem_err++;
        end else begin
          if (t_dir == 0) mem_err++;
          mem_rdata <= mdata(mem_addr);
        end
        mem_k++;
      end else begin
        prev_wait = 1'b1;
      end
    end else begin
      prev_wait = 1'b0;
    end
  end

  task automatic run_xfer(int dir, int ift, int a4, int nd, int len,
                          logic [31:0] fa, logic [31:0] mb,
                          logic [7:0] ro, logic [7:0] wo, bit poke);
    int guard, total;
    t_dir = dir; t_fa = fa; t_mb = mb;
    t_nab = a4 ? 4 : 3;
    t_nd  = dir ? 0 : nd;
    t_n   = (len > 4096) ? 4096 : len;
    t_aw  = lanes(ift, 1'b0);
    t_dw  = lanes(ift, 1'b1);
    t_opc = dir ? wo : ro;
    beat_k = 0; beat_err = 0; mem_k = 0; mem_err = 0; stall_err = 0; cs_rises = 0;
    @(negedge clk);
    mode_reg   = {a4[0], 9'b0, 1'b1};
    op_cfg     = {ift[2:0], 3'b000, nd[3:0]};
    flash_addr = fa;
    mem_base   = mb;
    xfer_len   = 28'(len);
    ctrl_word  = {ro, wo, 6'b0, dir[0], 1'b1};
    ctrl_we    = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      ctrl_word = {~ro, ~wo, 6'b0, ~dir[0], 1'b1};
      ctrl_we   = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b0;
    end
    guard = 0;
    while (!done && guard < 120000) begin @(negedge clk); guard++; end
    @(negedge clk);
    total = 8 + t_nab * 8 / t_aw + t_nd * 8 / t_aw + t_n * 8 / t_dw;
    // R2 R3 R4 R5 R7: every serial beat matches opcode, address, dummy and data
    check(beat_err == 0, "R2/R3/R4/R5/R7", "beat mismatches", beat_err, 0);
    // R8 R3 R4: beat count follows address width, dummy and clamped length
    check(beat_k == total, "R8/R3/R4", "serial beats", beat_k, total);
    // R6 R7 R8: one memory access per data byte
    check(mem_k == t_n, "R6/R7/R8", "memory accesses", mem_k, t_n);
    // R6: address and data of memory accesses
    check(mem_err == 0, "R6", "memory address/data errors", mem_err, 0);
    // R9: stall behaviour
    check(stall_err == 0, "R9", "stall violations", stall_err, 0);
    // R10: one chip select release per burst
    check(cs_rises == 1 && spi_cs_n == 1'b1, "R10", "chip select rises", cs_rises, 1);
    // R11: done set and held
    check(done == 1'b1, "R11", "done after burst", done, 1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    @(negedge clk);
    // R11: clear pulse
    check(done == 1'b0, "R11", "done after clear", done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 R11: reset state
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_io_oe == 4'b0, "R10",
          "idle serial pins", {spi_cs_n, spi_sck, spi_io_oe}, 6'b100000);
    check(done == 1'b0 && mem_req == 1'b0, "R11", "reset done/req", {done, mem_req}, 0);

    // R1: boot mode ignores the start bit
    cs_low = 0;
    mode_reg  = 11'b0;
    ctrl_word = 24'h030201;
    ctrl_we   = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (40) @(negedge clk);
    check(cs_low == 0 && done == 1'b0, "R1", "cycles with chip select low", cs_low, 0);

    run_xfer(0, 0, 0, 1, 5,   32'h00123456, 32'h1000, 8'h0B, 8'h02, 1'b0);
    run_xfer(0, 4, 1, 2, 17,  32'hA1B2C3D4, 32'h2000, 8'hEC, 8'h12, 1'b0);
    run_xfer(1, 1, 0, 7, 9,   32'h00ABCDEF, 32'h3000, 8'h3B, 8'h32, 1'b0);
    run_xfer(1, 2, 1, 0, 0,   32'h89ABCDEF, 32'h4000, 8'hBB, 8'h02, 1'b0);
    run_xfer(0, 3, 0, 1, 5000, 32'h00000100, 32'h8000, 8'h6B, 8'h32, 1'b0);
    // R11: start request during a burst is ignored
    run_xfer(0, 6, 1, 0, 12,  32'h01020304, 32'h5000, 8'h13, 8'h12, 1'b1);
    for (int i = 0; i < 8; i++) begin
      run_xfer($urandom_range(0, 1), $urandom_range(0, 4), $urandom_range(0, 1),
               $urandom_range(0, 3), $urandom_range(1, 40), $urandom, $urandom,
               8'($urandom), 8'($urandom), 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule